// File: doc/BRIEF.md
# Selectable Periodic Wakeup Timer

This block raises a wakeup interrupt at a programmable interval. It counts tick enables from one of two sources, picked by a source-select input: a nominal 1 kHz low-power tick, or a clock enable derived from an external crystal. A 3-bit rate code sets the interval, and the code value zero switches the timer off entirely.

The interval ladder is irregular. Code 1 is the shortest step. From code 2 upward the interval starts one power of two beyond the next doubling and then doubles with each further code. The same code is read as a tick count on the slow source and as a divide ratio on the crystal source. On every terminal count a sticky flag is set, and the prescaler restarts from zero in the same cycle, so successive intervals do not drift. The flag stays set until software acknowledges it. The interrupt output is the flag gated by an interrupt enable.

Top module: `wakeup_timer`

## Requirements
- R1: With rate code 3'b000 the prescaler is held and the flag is never set, whatever the ticks do.
- R2: With source select 0 (slow tick), rate codes 1..7 give intervals of 8, 32, 64, 128, 256, 512 and 1024 counted ticks.
- R3: With source select 1 (crystal enable), rate codes 1..7 give intervals of 256, 1024, 2048, 4096, 8192, 16384 and 32768 counted ticks.
- R4: Only the tick enable of the selected source advances the prescaler. The tick of the other source has no effect.
- R5: A clock cycle in which the sampled rate code or source select differs from the previous cycle clears the prescaler and counts no tick, so the first interval after the change is a full interval.
- R6: On the terminal tick the prescaler restarts from zero in the same cycle, so every following interval has exactly the same length.
- R7: The flag rises on the clock edge that samples the terminal tick and stays high until an acknowledge pulse clears it. If the acknowledge and a terminal tick fall in the same cycle, the flag is set.
- R8: The interrupt output is high exactly when the flag is high and the interrupt enable is high.
- R9: After reset the flag and the interrupt output are 0, the prescaler is 0 and the stored configuration is code 0 on the slow source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick_i | input | 1 | One-cycle enable from the nominal 1 kHz tick source |
| xtal_tick_i | input | 1 | One-cycle enable derived from the crystal clock |
| src_sel_i | input | 1 | Source select: 0 slow tick, 1 crystal enable |
| rate_i | input | 3 | Rate code. 0 means off, 1..7 select the interval |
| irq_en_i | input | 1 | Interrupt enable |
| ack_i | input | 1 | Acknowledge. Clears the flag |
| flag_o | output | 1 | Sticky wakeup flag |
| irq_o | output | 1 | Wakeup interrupt request |

## Verification
On every cycle, the assertions check that the prescaler never passes the terminal count of a stable configuration, that a configuration change clears it, and that it holds when no selected tick arrives. They also check that code zero never produces a terminal pulse, and that the flag sets, holds and clears as R7 describes. The actual interval lengths for all fourteen code and source pairs can only be shown by the bench's scenarios. The same is true of the absence of drift across consecutive intervals and of the full-length first interval after a switch of code or source. The bench measures these by counting ticks between flag events, while a behavioural model follows the outputs on every clock.

// File: rtl/wkt_pkg.sv
package wkt_pkg;

    // Tick source chosen by the source-select input
    typedef enum logic {
        SRC_SLOW = 1'b0,
        SRC_XTAL = 1'b1
    } wkt_src_e;

    // Rate code value that switches the timer off
    localparam logic [2:0] RATE_OFF = 3'd0;

endpackage

// File: rtl/wkt_period_map.sv
// Maps (rate code, source) to a terminal count, which is the interval minus one.
// The interval is 2**exp, with exp = base(src) + (code == 1 ? 0 : code).
module wkt_period_map #(
    parameter int CNT_W      = 15,
    parameter int RATE_W     = 3,
    parameter int SLOW_SHIFT = 3,
    parameter int XTAL_SHIFT = 8
) (
    input  logic              src_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic [CNT_W-1:0]  term_o
);
    localparam int EXP_W = $clog2(CNT_W + 1);

    logic [EXP_W-1:0] base_w;
    logic [EXP_W-1:0] step_w;
    logic [EXP_W-1:0] exp_w;

    always_comb begin
        base_w = (src_i == wkt_pkg::SRC_XTAL) ? EXP_W'(XTAL_SHIFT) : EXP_W'(SLOW_SHIFT);
        // the first step stays on the base; later codes skip one power of two
        step_w = (rate_i == RATE_W'(1)) ? '0 : EXP_W'(rate_i);
        exp_w  = base_w + step_w;
        term_o = ~({CNT_W{1'b1}} << exp_w);
    end

    initial begin
        assert (XTAL_SHIFT + (1 << RATE_W) - 1 <= CNT_W)
            else $error("prescaler too narrow for largest interval");
    end
endmodule

// File: rtl/wkt_prescaler.sv
module wkt_prescaler #(
    parameter int CNT_W  = 15,
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick_i,
    input  logic              xtal_tick_i,
    input  logic              src_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic [CNT_W-1:0]  term_i,
    output logic              set_o
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [RATE_W-1:0] rate_last;
        logic              src_last;
    } pre_state_t;

    pre_state_t st_q, st_d;
    logic       tick_w;
    logic       chg_w;
    logic       set_w;

    always_comb begin
        st_d   = st_q;
        set_w  = 1'b0;
        tick_w = (src_i == wkt_pkg::SRC_XTAL) ? xtal_tick_i : slow_tick_i;
        chg_w  = (rate_i != st_q.rate_last) || (src_i != st_q.src_last);
        st_d.rate_last = rate_i;
        st_d.src_last  = src_i;
        if (chg_w) begin
            st_d.cnt = '0;
        end else if ((rate_i != RATE_W'(wkt_pkg::RATE_OFF)) && tick_w) begin
            if (st_q.cnt == term_i) begin
                st_d.cnt = '0;
                set_w    = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign set_o = set_w;

    // R2 R3 R6: a stable configuration never counts past its terminal value
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_w |-> (st_q.cnt <= term_i));

    // R5: a configuration change leaves the prescaler at zero
    p_change_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        chg_w |=> (st_q.cnt == '0));

    // R4: without a selected tick the prescaler holds
    p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_w && !chg_w) |=> $stable(st_q.cnt));

    // R1: code zero never yields a terminal pulse
    p_off_no_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_i == RATE_W'(wkt_pkg::RATE_OFF)) |-> !set_w);
endmodule

// File: rtl/wkt_flag.sv
module wkt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic ack_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);
    logic flag_q, flag_d;

    always_comb begin
        // set has priority over acknowledge
        flag_d = set_i | (flag_q & ~ack_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q & irq_en_i;

    // R7: a terminal pulse always leaves the flag set, even with acknowledge
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q);

    // R7: acknowledge without a terminal pulse clears the flag
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !set_i) |=> !flag_q);

    // R7: the flag is sticky while neither input acts
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !ack_i) |=> flag_q);

    // R8: no interrupt while disabled
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |-> !irq_o);
endmodule

// File: rtl/wakeup_timer.sv
module wakeup_timer #(
    parameter int CNT_W      = 15,
    parameter int RATE_W     = 3,
    parameter int SLOW_SHIFT = 3,
    parameter int XTAL_SHIFT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick_i,
    input  logic              xtal_tick_i,
    input  logic              src_sel_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              irq_en_i,
    input  logic              ack_i,
    output logic              flag_o,
    output logic              irq_o
);
    logic [CNT_W-1:0] term_w;
    logic             set_w;

    wkt_period_map #(
        .CNT_W      (CNT_W),
        .RATE_W     (RATE_W),
        .SLOW_SHIFT (SLOW_SHIFT),
        .XTAL_SHIFT (XTAL_SHIFT)
    ) u_map (
        .src_i  (src_sel_i),
        .rate_i (rate_i),
        .term_o (term_w)
    );

    wkt_prescaler #(
        .CNT_W  (CNT_W),
        .RATE_W (RATE_W)
    ) u_pre (
        .clk         (clk),
        .rst_n       (rst_n),
        .slow_tick_i (slow_tick_i),
        .xtal_tick_i (xtal_tick_i),
        .src_i       (src_sel_i),
        .rate_i      (rate_i),
        .term_i      (term_w),
        .set_o       (set_w)
    );

    wkt_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_w),
        .ack_i    (ack_i),
        .irq_en_i (irq_en_i),
        .flag_o   (flag_o),
        .irq_o    (irq_o)
    );

    // R9: the first sampled cycle after reset shows a clear flag
    p_reset_clear_r9: assert property (@(posedge clk)
        $rose(rst_n) |-> !flag_o);
endmodule

// File: tb/wakeup_timer_test.sv
`timescale 1ns/1ps
module wakeup_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_tick = 1'b0;
    logic       xtal_tick = 1'b0;
    logic       src_sel = 1'b0;
    logic [2:0] rate = 3'd0;
    logic       irq_en = 1'b0;
    logic       ack = 1'b0;
    logic       flag_o;
    logic       irq_o;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R9";

    always #2.5 clk = ~clk;

    wakeup_timer uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .slow_tick_i (slow_tick),
        .xtal_tick_i (xtal_tick),
        .src_sel_i   (src_sel),
        .rate_i      (rate),
        .irq_en_i    (irq_en),
        .ack_i       (ack),
        .flag_o      (flag_o),
        .irq_o       (irq_o)
    );

    // interval tables taken from R2 and R3
    function automatic int model_period(bit s, int c);
        if (!s) begin
            case (c)
                1: return 8;    2: return 32;   3: return 64;   4: return 128;
                5: return 256;  6: return 512;  7: return 1024;
                default: return 0;
            endcase
        end else begin
            case (c)
                1: return 256;  2: return 1024; 3: return 2048; 4: return 4096;
                5: return 8192; 6: return 16384; 7: return 32768;
                default: return 0;
            endcase
        end
    endfunction

    // behavioural reference model
    int m_cnt = 0;
    int m_rate_prev = 0;
    bit m_src_prev = 0;
    bit m_flag = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_rate_prev = 0; m_src_prev = 0; m_flag = 0;
        end else begin
            bit tk, set;
            set = 0;
            tk = src_sel ? xtal_tick : slow_tick;
            if (int'(rate) != m_rate_prev || src_sel != m_src_prev) begin
                m_cnt = 0;
            end else if (rate != 0 && tk) begin
                m_cnt++;
                if (m_cnt == model_period(src_sel, int'(rate))) begin
                    m_cnt = 0;
                    set = 1;
                end
            end
            m_flag = set | (m_flag & !ack);
            m_rate_prev = int'(rate);
            m_src_prev = src_sel;
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        check(flag_o == m_flag, {cur_req, " flag"}, int'(flag_o), int'(m_flag));
        check(irq_o == (m_flag & irq_en), {cur_req, " irq R8"}, int'(irq_o), int'(m_flag & irq_en));
    end

    task automatic cfg(bit s, int c);
        @(posedge clk); #1;
        rate = 3'd0; ack = 1'b1; slow_tick = 1'b0; xtal_tick = 1'b0;
        @(posedge clk); #1;
        src_sel = s; rate = 3'(c);
        @(posedge clk); #1;
        ack = 1'b0;
    endtask

    // counts tick edges until the flag is seen
    task automatic count_to_flag(output int n);
        n = 0;
        slow_tick = 1'b1; xtal_tick = 1'b1;
        while (n < 40000) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (flag_o) break;
        end
    endtask

    task automatic measure(bit s, int c, string req, bit twice);
        int n;
        cfg(s, c);
        count_to_flag(n);
        check(n == model_period(s, c), req, n, model_period(s, c));
        if (twice) begin
            ack = 1'b1;   // held: flag clears, then the set must win (R7)
            n = 0;
            @(posedge clk); n++;
            @(negedge clk);
            check(flag_o == 1'b0, "R7 ack clears", int'(flag_o), 0);
            while (n < 40000) begin
                @(posedge clk); n++;
                @(negedge clk);
                if (flag_o) break;
            end
            check(n == model_period(s, c), "R6 R7 second interval", n, model_period(s, c));
            ack = 1'b0;
        end
    endtask

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #1;
        check(flag_o == 1'b0 && irq_o == 1'b0, "R9 reset outputs", int'(flag_o | irq_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(flag_o == 1'b0, "R9 after reset", int'(flag_o), 0);

        // R1: code zero with ticks on both sources
        cur_req = "R1";
        @(posedge clk); #1;
        slow_tick = 1'b1; xtal_tick = 1'b1; rate = 3'd0;
        repeat (2000) @(posedge clk);
        @(negedge clk);
        check(flag_o == 1'b0, "R1 off never flags", int'(flag_o), 0);
        src_sel = 1'b1;
        repeat (300) @(posedge clk);
        @(negedge clk);
        check(flag_o == 1'b0, "R1 off on crystal", int'(flag_o), 0);

        // R2, R6, R7 on the slow source
        cur_req = "R2";
        measure(1'b0, 1, "R2 code1", 1'b1);
        measure(1'b0, 2, "R2 code2", 1'b1);
        for (int c = 3; c <= 7; c++) measure(1'b0, c, "R2 ladder", 1'b0);

        // R3 on the crystal source
        cur_req = "R3";
        for (int c = 1; c <= 7; c++) measure(1'b1, c, "R3 ladder", c == 1);

        // R8: gating
        cur_req = "R8";
        @(posedge clk); #1; irq_en = 1'b0;
        @(negedge clk);
        check(irq_o == 1'b0 && flag_o == 1'b1, "R8 irq masked", int'(irq_o), 0);
        @(posedge clk); #1; irq_en = 1'b1;
        @(negedge clk);
        check(irq_o == 1'b1, "R8 irq enabled", int'(irq_o), 1);

        // R4: unselected source has no effect
        cur_req = "R4";
        cfg(1'b0, 1);
        @(posedge clk); #1; slow_tick = 1'b0; xtal_tick = 1'b1;
        repeat (600) @(posedge clk);
        @(negedge clk);
        check(flag_o == 1'b0, "R4 crystal ticks ignored on slow", int'(flag_o), 0);
        cfg(1'b1, 1);
        @(posedge clk); #1; slow_tick = 1'b1; xtal_tick = 1'b0;
        repeat (600) @(posedge clk);
        @(negedge clk);
        check(flag_o == 1'b0, "R4 slow ticks ignored on crystal", int'(flag_o), 0);

        // R5: rate change mid-interval restarts the prescaler
        cur_req = "R5";
        cfg(1'b0, 2);
        @(posedge clk); #1; slow_tick = 1'b1;
        repeat (20) @(posedge clk);
        #1; rate = 3'd1; slow_tick = 1'b0;
        @(posedge clk); #1;
        count_to_flag(n);
        check(n == 8, "R5 rate change full interval", n, 8);
        // R5: source change with the same code
        cfg(1'b0, 1);
        @(posedge clk); #1; slow_tick = 1'b1; xtal_tick = 1'b1;
        repeat (5) @(posedge clk);
        #1; src_sel = 1'b1; slow_tick = 1'b0; xtal_tick = 1'b0;
        @(posedge clk); #1;
        count_to_flag(n);
        check(n == 256, "R5 source change full interval", n, 256);

        // mixed random traffic, compared every cycle with the model
        cur_req = "R4 R5 R7";
        for (int i = 0; i < 4000; i++) begin
            @(posedge clk); #1;
            slow_tick = ($urandom_range(0, 1) == 1);
            xtal_tick = ($urandom_range(0, 2) == 0);
            ack       = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 99) == 0) irq_en = ~irq_en;
            if ($urandom_range(0, 299) == 0) rate = 3'($urandom_range(0, 2));
            if ($urandom_range(0, 399) == 0) src_sel = ~src_sel;
        end
        @(posedge clk); #1;
        slow_tick = 1'b0; xtal_tick = 1'b0; ack = 1'b0;
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule